// File: doc/BRIEF.md
# One-Wire Temperature Sensor Poller

This block is a command sequencer that sits on top of a bit-slot one-wire master. It reads the 64-bit identity of a single temperature sensor on the first start strobe. On every start strobe it also fetches the sensor's last converted temperature and then starts a fresh conversion. All traffic is built from bit slots. Each slot is passed to the bus master through a request/acknowledge handshake, and the master returns one sampled bit for every slot.

A poll addresses the sensor by its stored identity and reads the scratchpad. It then addresses the sensor again and issues the convert command. Because of this order, every poll reports the conversion that the previous poll started. The first poll after power-up therefore returns a value that software treats as undefined. A missing presence response or a write byte whose echo differs from the bits sent aborts the sequence and raises a sticky error flag.

Top module: `owtemp_poller`

## Requirements
- R1: After reset, `id_o`, `temp_o`, `id_valid_o`, `temp_valid_o`, `error_o`, `busy_o` and `slot_req_o` are all zero.
- R2: While `slot_req_o` is high and `slot_ack_i` is low, the request, `slot_rst_o` and `slot_bit_o` stay unchanged. Each cycle with both `slot_req_o` and `slot_ack_i` high completes exactly one slot, and `slot_bit_i` is sampled in that cycle.
- R3: A byte uses 8 data slots (`slot_rst_o`=0), least-significant bit first. A write slot drives the bit on `slot_bit_o`. A read slot drives `slot_bit_o`=1 and collects `slot_bit_i` into the byte LSB first.
- R4: When no identity is held, a start first performs a reset slot, writes 0x33 and reads 8 bytes. The k-th byte received goes to `id_o[8k+7:8k]`, and `id_valid_o` then rises and stays high.
- R5: A poll is: reset slot, 0x55, the 8 identity bytes from byte 0 upward, 0xBE, 9 read bytes, reset slot, 0x55, the 8 identity bytes, then 0x44. Once an identity is held, a start performs only the poll.
- R6: The temperature is formed as raw = {scratchpad byte 1, byte 0}. If raw bit 12 is set, `temp_o` = raw − 65536 as a two's-complement 32-bit value (upper 16 bits all ones). Otherwise `temp_o` is raw zero-extended.
- R7: At the completion of a poll, `temp_o` updates and `temp_valid_o` is high for exactly one cycle, with `busy_o` falling in that same cycle.
- R8: A reset slot answered with `slot_bit_i`=0 (no presence) aborts the sequence. No further slot is issued, `error_o` rises, and `temp_o` and `id_o` keep their values.
- R9: If the 8 bits sampled during a written byte differ from the byte sent, the sequence aborts with `error_o` set, no further slot and no `temp_valid_o` pulse.
- R10: `error_o` stays high until the next accepted start, which clears it in the following cycle.
- R11: A start strobe while `busy_o` is high is ignored; the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start/poll strobe |
| slot_req_o | output | 1 | Bit slot requested from the bus master |
| slot_rst_o | output | 1 | Requested slot is a reset/presence slot |
| slot_bit_o | output | 1 | Bit to drive in a data slot (1 for reads) |
| slot_ack_i | input | 1 | Bus master finished the requested slot |
| slot_bit_i | input | 1 | Sampled bit; for a reset slot, 1 = presence |
| id_o | output | 64 | Stored sensor identity, byte 0 in bits 7:0 |
| id_valid_o | output | 1 | Identity has been read |
| temp_o | output | 32 | Last latched temperature, sign-handled per R6 |
| temp_valid_o | output | 1 | One-cycle pulse when a new temperature is latched |
| error_o | output | 1 | Sticky error from presence or echo failure |
| busy_o | output | 1 | A sequence is running |

## Verification
A bench-side sensor model plays back a slot script and compares every slot the block requests against it, so any deviation in order, bit polarity, LSB-first ordering or slot count shows up. Scratchpad values are swept over all sixteen top-nibble patterns with varying low bits, which separates a sign test on bit 12 from one on bit 15 and from plain zero extension. Fault scripts withhold presence or corrupt one echoed bit of the match command, which tells a real abort apart from a sequence that carries on or latches a value. A start strobe injected mid-poll shows whether busy strobes restart the sequence.

// File: rtl/owtp_pkg.sv
package owtp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_RST = 2'd0,
    OP_WR  = 2'd1,
    OP_RD  = 2'd2
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_ID_RST = 4'd1,
    ST_ID_CMD = 4'd2,
    ST_ID_RD  = 4'd3,
    ST_A_RST  = 4'd4,
    ST_A_MAT  = 4'd5,
    ST_A_ID   = 4'd6,
    ST_A_FN   = 4'd7,
    ST_SP_RD  = 4'd8,
    ST_B_RST  = 4'd9,
    ST_B_MAT  = 4'd10,
    ST_B_ID   = 4'd11,
    ST_B_CONV = 4'd12
  } step_e;

  // command codes understood by the sensor
  localparam logic [7:0] CMD_READ_ID = 8'h33;
  localparam logic [7:0] CMD_MATCH   = 8'h55;
  localparam logic [7:0] CMD_READ_SP = 8'hBE;
  localparam logic [7:0] CMD_CONVERT = 8'h44;

  // byte 1 is the high half, byte 0 the low half
  function automatic logic [15:0] temp_raw(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  // sign indicator of the sensor format sits at bit 12
  function automatic logic temp_is_neg(input logic [15:0] raw);
    return raw[12];
  endfunction

endpackage

// File: rtl/owtp_slot_engine.sv
module owtp_slot_engine
  import owtp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  op_e                 op_i,
  input  logic [BYTE_W-1:0]   wbyte_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o,
  output logic [BYTE_W-1:0]   rbyte_o,
  output logic                slot_req_o,
  output logic                slot_rst_o,
  output logic                slot_bit_o,
  input  logic                slot_ack_i,
  input  logic                slot_bit_i
);

  localparam int CW = $clog2(BYTE_W);

  logic              req_q;
  op_e               op_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] sent_q;
  logic [BYTE_W-1:0] rx_q;
  logic [CW-1:0]     cnt_q;

  logic              slot_fire;
  logic              slot_last;
  logic [BYTE_W-1:0] rx_next;
  logic              no_presence;
  logic              echo_bad;

  assign slot_fire   = req_q && slot_ack_i;
  assign slot_last   = (op_q == OP_RST) || (cnt_q == CW'(BYTE_W - 1));
  assign rx_next     = {slot_bit_i, rx_q[BYTE_W-1:1]};
  assign no_presence = (op_q == OP_RST) && !slot_bit_i;
  assign echo_bad    = (op_q == OP_WR) && (rx_next != sent_q);

  assign busy_o     = req_q;
  assign done_o     = slot_fire && slot_last;
  assign fail_o     = done_o && (no_presence || echo_bad);
  assign rbyte_o    = rx_next;
  assign slot_req_o = req_q;
  assign slot_rst_o = (op_q == OP_RST);
  assign slot_bit_o = (op_q == OP_WR) ? tx_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      op_q   <= OP_RST;
      tx_q   <= '0;
      sent_q <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else if (go_i && !req_q) begin
      req_q  <= 1'b1;
      op_q   <= op_i;
      tx_q   <= wbyte_i;
      sent_q <= wbyte_i;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else if (slot_fire) begin
      rx_q  <= rx_next;
      tx_q  <= tx_q >> 1;
      cnt_q <= cnt_q + CW'(1);
      if (slot_last) req_q <= 1'b0;
    end
  end

  assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_ack_i) |=> (slot_req_o && $stable(slot_rst_o) && $stable(slot_bit_o)));

  assert_go_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !req_q);

endmodule

// File: rtl/owtp_id_store.sv
module owtp_id_store
  import owtp_pkg::*;
#(
  parameter int N_BYTES = 8,
  localparam int AW = $clog2(N_BYTES)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [AW-1:0]             idx_i,
  input  logic [BYTE_W-1:0]         wdata_i,
  output logic [BYTE_W-1:0]         rdata_o,
  output logic [N_BYTES*BYTE_W-1:0] id_o
);

  logic [BYTE_W-1:0] bytes_q [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              bytes_q[g] <= '0;
      else if (wr_i && (idx_i == AW'(g)))      bytes_q[g] <= wdata_i;
    end
    assign id_o[g*BYTE_W +: BYTE_W] = bytes_q[g];
  end

  assign rdata_o = bytes_q[idx_i];

endmodule

// File: rtl/owtp_sequencer.sv
module owtp_sequencer
  import owtp_pkg::*;
#(
  parameter int ID_BYTES = 8,
  parameter int SP_BYTES = 9,
  parameter int TW       = 32,
  localparam int MAXB    = (ID_BYTES > SP_BYTES) ? ID_BYTES : SP_BYTES,
  localparam int IW      = $clog2(MAXB)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic              eng_fail_i,
  input  logic [BYTE_W-1:0] eng_rbyte_i,
  input  logic [BYTE_W-1:0] id_byte_i,
  output logic              eng_go_o,
  output op_e               eng_op_o,
  output logic [BYTE_W-1:0] eng_wbyte_o,
  output logic [IW-1:0]     idx_o,
  output logic              id_wr_o,
  output logic              busy_o,
  output logic              error_o,
  output logic              id_valid_o,
  output logic [TW-1:0]     temp_o,
  output logic              temp_valid_o
);

  step_e             step_q;
  logic [IW-1:0]     idx_q;
  logic              error_q;
  logic              idv_q;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;
  logic [TW-1:0]     temp_q;
  logic              tvalid_q;

  logic              start_ok;
  logic              step_ok;
  logic              id_last;
  logic              sp_last;
  logic [15:0]       raw_w;

  assign start_ok = start_i && (step_q == ST_IDLE);
  assign step_ok  = eng_done_i && !eng_fail_i;
  assign id_last  = (idx_q == IW'(ID_BYTES - 1));
  assign sp_last  = (idx_q == IW'(SP_BYTES - 1));
  assign raw_w    = temp_raw(lo_q, hi_q);

  assign eng_go_o = (step_q != ST_IDLE) && !eng_busy_i;
  assign id_wr_o  = step_ok && (step_q == ST_ID_RD);
  assign idx_o    = idx_q;

  always_comb begin
    eng_op_o    = OP_WR;
    eng_wbyte_o = '0;
    unique case (step_q)
      ST_ID_RST, ST_A_RST, ST_B_RST: eng_op_o = OP_RST;
      ST_ID_RD, ST_SP_RD:            eng_op_o = OP_RD;
      ST_ID_CMD:                     eng_wbyte_o = CMD_READ_ID;
      ST_A_MAT, ST_B_MAT:            eng_wbyte_o = CMD_MATCH;
      ST_A_ID, ST_B_ID:              eng_wbyte_o = id_byte_i;
      ST_A_FN:                       eng_wbyte_o = CMD_READ_SP;
      ST_B_CONV:                     eng_wbyte_o = CMD_CONVERT;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= ST_IDLE;
      idx_q    <= '0;
      error_q  <= 1'b0;
      idv_q    <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      temp_q   <= '0;
      tvalid_q <= 1'b0;
    end else begin
      tvalid_q <= 1'b0;
      if (start_ok) begin
        error_q <= 1'b0;
        idx_q   <= '0;
        step_q  <= idv_q ? ST_A_RST : ST_ID_RST;
      end else if (eng_done_i && eng_fail_i) begin
        error_q <= 1'b1;
        step_q  <= ST_IDLE;
      end else if (step_ok) begin
        unique case (step_q)
          ST_ID_RST: step_q <= ST_ID_CMD;
          ST_ID_CMD: begin step_q <= ST_ID_RD; idx_q <= '0; end
          ST_ID_RD: begin
            if (id_last) begin
              idv_q  <= 1'b1;
              idx_q  <= '0;
              step_q <= ST_A_RST;
            end else idx_q <= idx_q + IW'(1);
          end
          ST_A_RST: step_q <= ST_A_MAT;
          ST_A_MAT: begin step_q <= ST_A_ID; idx_q <= '0; end
          ST_A_ID: begin
            if (id_last) begin step_q <= ST_A_FN; idx_q <= '0; end
            else idx_q <= idx_q + IW'(1);
          end
          ST_A_FN: begin step_q <= ST_SP_RD; idx_q <= '0; end
          ST_SP_RD: begin
            if (idx_q == IW'(0)) lo_q <= eng_rbyte_i;
            if (idx_q == IW'(1)) hi_q <= eng_rbyte_i;
            if (sp_last) begin step_q <= ST_B_RST; idx_q <= '0; end
            else idx_q <= idx_q + IW'(1);
          end
          ST_B_RST: step_q <= ST_B_MAT;
          ST_B_MAT: begin step_q <= ST_B_ID; idx_q <= '0; end
          ST_B_ID: begin
            if (id_last) begin step_q <= ST_B_CONV; idx_q <= '0; end
            else idx_q <= idx_q + IW'(1);
          end
          ST_B_CONV: begin
            temp_q   <= {{(TW-16){temp_is_neg(raw_w)}}, raw_w};
            tvalid_q <= 1'b1;
            step_q   <= ST_IDLE;
          end
          default: step_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o       = (step_q != ST_IDLE);
  assign error_o      = error_q;
  assign id_valid_o   = idv_q;
  assign temp_o       = temp_q;
  assign temp_valid_o = tvalid_q;

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid_o |=> !temp_valid_o);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (error_o && !start_i) |=> error_o);

  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !eng_done_i) |=> (busy_o && $stable(idx_o)));

  assert_id_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid_o |=> id_valid_o);

endmodule

// File: rtl/owtemp_poller.sv
module owtemp_poller
  import owtp_pkg::*;
#(
  parameter int ID_BYTES = 8,
  parameter int SP_BYTES = 9,
  parameter int TW       = 32,
  localparam int MAXB    = (ID_BYTES > SP_BYTES) ? ID_BYTES : SP_BYTES,
  localparam int IW      = $clog2(MAXB),
  localparam int AW      = $clog2(ID_BYTES)
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  output logic                         slot_req_o,
  output logic                         slot_rst_o,
  output logic                         slot_bit_o,
  input  logic                         slot_ack_i,
  input  logic                         slot_bit_i,
  output logic [ID_BYTES*BYTE_W-1:0]   id_o,
  output logic                         id_valid_o,
  output logic [TW-1:0]                temp_o,
  output logic                         temp_valid_o,
  output logic                         error_o,
  output logic                         busy_o
);

  // internal events, named for the checks below
  logic              eng_go;
  op_e               eng_op;
  logic [BYTE_W-1:0] eng_wbyte;
  logic              eng_busy;
  logic              eng_done;
  logic              eng_fail;
  logic [BYTE_W-1:0] eng_rbyte;
  logic [IW-1:0]     seq_idx;
  logic              id_wr;
  logic [BYTE_W-1:0] id_byte;
  logic              seq_abort;

  assign seq_abort = eng_done && eng_fail;

  owtp_slot_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (eng_go),
    .op_i       (eng_op),
    .wbyte_i    (eng_wbyte),
    .busy_o     (eng_busy),
    .done_o     (eng_done),
    .fail_o     (eng_fail),
    .rbyte_o    (eng_rbyte),
    .slot_req_o (slot_req_o),
    .slot_rst_o (slot_rst_o),
    .slot_bit_o (slot_bit_o),
    .slot_ack_i (slot_ack_i),
    .slot_bit_i (slot_bit_i)
  );

  owtp_id_store #(.N_BYTES(ID_BYTES)) u_ids (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (id_wr),
    .idx_i   (seq_idx[AW-1:0]),
    .wdata_i (eng_rbyte),
    .rdata_o (id_byte),
    .id_o    (id_o)
  );

  owtp_sequencer #(.ID_BYTES(ID_BYTES), .SP_BYTES(SP_BYTES), .TW(TW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .eng_busy_i   (eng_busy),
    .eng_done_i   (eng_done),
    .eng_fail_i   (eng_fail),
    .eng_rbyte_i  (eng_rbyte),
    .id_byte_i    (id_byte),
    .eng_go_o     (eng_go),
    .eng_op_o     (eng_op),
    .eng_wbyte_o  (eng_wbyte),
    .idx_o        (seq_idx),
    .id_wr_o      (id_wr),
    .busy_o       (busy_o),
    .error_o      (error_o),
    .id_valid_o   (id_valid_o),
    .temp_o       (temp_o),
    .temp_valid_o (temp_valid_o)
  );

  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (error_o && !busy_o && !slot_req_o));

  assert_abort_keeps_temp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (!temp_valid_o && $stable(temp_o)));

  assert_no_valid_with_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid_o |-> !error_o);

  assert_valid_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid_o |-> !busy_o);

endmodule

// File: tb/test_owtemp_poller.sv
module test_owtemp_poller;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        slot_req_o, slot_rst_o, slot_bit_o;
  logic        slot_ack_i = 1'b0;
  logic        slot_bit_i = 1'b0;
  logic [63:0] id_o;
  logic        id_valid_o;
  logic [31:0] temp_o;
  logic        temp_valid_o, error_o, busy_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // slot script played by the sensor model
  logic t_rst  [0:511];
  logic t_bit  [0:511];
  logic t_resp [0:511];
  int   t_len = 0;
  int   t_pos = 0;
  int   wait_cnt = 0;
  int   valid_cnt = 0;
  logic [7:0] idb [0:7];

  owtemp_poller i_owtemp_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .slot_req_o(slot_req_o), .slot_rst_o(slot_rst_o), .slot_bit_o(slot_bit_o),
    .slot_ack_i(slot_ack_i), .slot_bit_i(slot_bit_i),
    .id_o(id_o), .id_valid_o(id_valid_o), .temp_o(temp_o),
    .temp_valid_o(temp_valid_o), .error_o(error_o), .busy_o(busy_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_temp(input int raw);
    int v;
    v = raw;
    if ((raw / 4096) % 2 == 1) v = raw - 65536;
    return v;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) if (temp_valid_o) valid_cnt++;

  // sensor model: acknowledges each request after a short varying delay
  always @(negedge clk) begin
    if (slot_ack_i) begin
      slot_ack_i = 1'b0;
    end else if (slot_req_o && rst_n) begin
      if (wait_cnt < (t_pos % 3)) begin
        wait_cnt++;
      end else begin
        wait_cnt = 0;
        if (t_pos >= t_len) begin
          check(1'b0, "R5 slot beyond script", 64'(t_pos), 64'(t_len));
          slot_bit_i = 1'b1;
        end else begin
          check(slot_rst_o == t_rst[t_pos], "R3/R5 slot kind", 64'(slot_rst_o), 64'(t_rst[t_pos]));
          if (!t_rst[t_pos])
            check(slot_bit_o == t_bit[t_pos], "R3 slot bit", 64'(slot_bit_o), 64'(t_bit[t_pos]));
          slot_bit_i = t_resp[t_pos];
        end
        t_pos++;
        slot_ack_i = 1'b1;
      end
    end
  end

  task automatic s_clear();
    t_len = 0; t_pos = 0;
  endtask
  task automatic s_rst(input logic pres);
    t_rst[t_len] = 1'b1; t_bit[t_len] = 1'b1; t_resp[t_len] = pres; t_len++;
  endtask
  task automatic s_wr(input logic [7:0] b, input logic [7:0] flip);
    for (int i = 0; i < 8; i++) begin
      t_rst[t_len] = 1'b0; t_bit[t_len] = b[i]; t_resp[t_len] = b[i] ^ flip[i]; t_len++;
    end
  endtask
  task automatic s_rd(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      t_rst[t_len] = 1'b0; t_bit[t_len] = 1'b1; t_resp[t_len] = b[i]; t_len++;
    end
  endtask
  task automatic s_idread();
    s_rst(1'b1); s_wr(8'h33, 8'h00);
    for (int k = 0; k < 8; k++) s_rd(idb[k]);
  endtask
  task automatic s_poll(input logic [7:0] lo, input logic [7:0] hi);
    s_rst(1'b1); s_wr(8'h55, 8'h00);
    for (int k = 0; k < 8; k++) s_wr(idb[k], 8'h00);
    s_wr(8'hBE, 8'h00);
    s_rd(lo); s_rd(hi);
    for (int k = 2; k < 9; k++) s_rd(8'(k * 17));
    s_rst(1'b1); s_wr(8'h55, 8'h00);
    for (int k = 0; k < 8; k++) s_wr(idb[k], 8'h00);
    s_wr(8'h44, 8'h00);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (busy_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check(1'b0, "R5 sequence hung", 64'(n), 64'(0));
    @(negedge clk);
  endtask

  task automatic run_poll(input int raw, input string tag);
    logic [31:0] e;
    s_clear();
    s_poll(8'(raw % 256), 8'(raw / 256));
    valid_cnt = 0;
    pulse_start();
    wait_idle();
    e = exp_temp(raw);
    check(temp_o == e, {tag, " R6 temperature"}, 64'(temp_o), 64'(e));
    check(valid_cnt == 1, {tag, " R7 one valid pulse"}, 64'(valid_cnt), 64'(1));
    check(t_pos == t_len, {tag, " R5 slot count"}, 64'(t_pos), 64'(t_len));
    check(error_o == 1'b0, {tag, " R9 no error"}, 64'(error_o), 64'(0));
  endtask

  initial begin
    logic [63:0] eid;
    logic [31:0] keep;
    for (int k = 0; k < 8; k++) idb[k] = 8'(8'h28 + k * 8'h13);
    eid = '0;
    for (int k = 0; k < 8; k++) eid[k*8 +: 8] = idb[k];

    repeat (3) @(negedge clk);
    // R1 reset state
    check(id_o == 64'd0 && temp_o == 32'd0, "R1 reset data", {id_o[31:0], temp_o}, 64'd0);
    check(!id_valid_o && !temp_valid_o && !error_o && !busy_o && !slot_req_o,
          "R1 reset flags", 64'({id_valid_o, temp_valid_o, error_o, busy_o, slot_req_o}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 first start: identity read then poll
    s_clear(); s_idread(); s_poll(8'h50, 8'h05);
    valid_cnt = 0;
    pulse_start();
    wait_idle();
    check(id_valid_o == 1'b1, "R4 id valid", 64'(id_valid_o), 64'(1));
    check(id_o == eid, "R4 id bytes in arrival order", id_o, eid);
    check(temp_o == 32'h0000_0550, "R6 positive first poll", 64'(temp_o), 64'h550);
    check(valid_cnt == 1, "R7 one pulse", 64'(valid_cnt), 64'(1));
    check(t_pos == t_len, "R4 slot count", 64'(t_pos), 64'(t_len));

    // R11 start while busy ignored, negative value
    s_clear(); s_poll(8'h5E, 8'hFF);
    valid_cnt = 0;
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_idle();
    check(t_pos == t_len, "R11 busy start ignored", 64'(t_pos), 64'(t_len));
    check(temp_o == 32'hFFFF_FF5E, "R6 negative", 64'(temp_o), 64'hFFFFFF5E);
    check(valid_cnt == 1, "R11 one pulse", 64'(valid_cnt), 64'(1));

    // R6 sweep over every top nibble
    for (int k = 0; k < 16; k++) run_poll(k * 4096 + ((k * 389 + 7) % 4096), "sweep");

    // R9 echo mismatch on match command
    keep = temp_o;
    s_clear(); s_rst(1'b1); s_wr(8'h55, 8'h04);
    valid_cnt = 0;
    pulse_start();
    wait_idle();
    check(error_o == 1'b1, "R9 echo error", 64'(error_o), 64'(1));
    check(valid_cnt == 0 && temp_o == keep, "R9 no latch", 64'(temp_o), 64'(keep));
    check(t_pos == t_len, "R9 abort stops slots", 64'(t_pos), 64'(t_len));
    repeat (20) @(negedge clk);
    check(error_o == 1'b1 && !slot_req_o, "R10 error sticky", 64'(error_o), 64'(1));

    // R8 no presence; R10 start clears error
    s_clear(); s_rst(1'b0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(error_o == 1'b0, "R10 start clears error", 64'(error_o), 64'(0));
    wait_idle();
    repeat (10) @(negedge clk);
    check(error_o == 1'b1, "R8 presence error", 64'(error_o), 64'(1));
    check(t_pos == t_len, "R8 abort stops slots", 64'(t_pos), 64'(t_len));
    check(id_valid_o && id_o == eid && temp_o == keep, "R8 state kept", id_o, eid);

    // recovery
    run_poll(16'h0191, "recover");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule